// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns a single host write request into a correctly timed write cycle on an asynchronous static RAM. The memory has a pair of chip enables of opposite polarity (one active low, one active high), an active-low write strobe and an active-low output enable. The memory stores data only while both enables are active and the write strobe is low. Removing any one of the three ends the store.

The host offers an address and a data word with `req_valid`. The request is taken on a clock edge where `req_ready` is high. The sequencer then runs four timed phases. In the address phase the address is held before the write window opens. In the strobe phase the window is open. In the recovery phase the address and data are held after the window closes. A final cycle reports completion on `wr_done`. Each phase length is a whole number of clock cycles set by a parameter.

A build-time option selects the signal that ends the cycle. With the strobe ending it, the enables frame a pulse on the write strobe. With the enables ending it, the strobe frames a pulse on the enables. The data-bus drive window always sits around whichever edge closes the write.

Top module: `sram_wr_ctrl`

## Requirements
- R1: After reset `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `wr_done`=0 and `req_ready`=1.
- R2: `mem_oe_n` is 1 in every cycle.
- R3: For each accepted request, the write window (`mem_ce1_n`=0, `mem_ce2`=1, `mem_we_n`=0) is open for exactly `PW_CYC` consecutive cycles and opens exactly once.
- R4: With `END_BY_CE`=0, the enables go active `AS_CYC` cycles before the strobe falls. They stay active for `WR_CYC` cycles after the strobe rises, so the strobe closes the window.
- R5: With `END_BY_CE`=1, the strobe goes low `AS_CYC` cycles before the enables go active. It stays low for `WR_CYC` cycles after the enables go inactive, so the enables close the window. The two enables always switch in the same cycle.
- R6: `mem_addr` equals the accepted address and does not change in any cycle from the start of the address phase to the end of recovery.
- R7: `mem_dq_oe` is 1 for exactly the last `DW_CYC` cycles of the window and the first `DH_CYC` cycles after it. While it is 1, `mem_dq_out` equals the accepted data.
- R8: `wr_done` is 1 for exactly one cycle per write. That cycle immediately follows recovery, and in it the memory pins are back at their reset values.
- R9: `req_ready` is 1 only while no write is in progress. A request held high during a write is taken after that write ends and is then carried out with the address and data present at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host write request |
| req_ready | output | 1 | Sequencer idle; request taken on this edge if valid |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| wr_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | DATA_W | Data to memory bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low (held inactive) |

## Verification
The checker assumes a valid build-time configuration: all counts are at least one, the setup count does not exceed the window length, and the hold count does not exceed recovery. It also assumes the host keeps `req_valid` as a level that is sampled only against `req_ready`. The bench presents requests only at falling clock edges and holds them until acceptance. It mixes random addresses, data and idle gaps with back-to-back requests and requests held through a busy cycle. Two instances, one per termination mode, receive the same stimulus.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_PULSE = 3'd2,
      PH_RECOV = 3'd3,
      PH_DONE  = 3'd4
   } wr_phase_e;

   typedef struct packed {
      logic ce1_n;
      logic ce2;
      logic we_n;
      logic oe_n;
      logic drive;
      logic done;
   } pin_set_t;

   localparam pin_set_t PINS_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1,
                                      oe_n: 1'b1, drive: 1'b0, done: 1'b0};

   function automatic int cnt_width(input int max_count);
      return (max_count < 2) ? 1 : $clog2(max_count);
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/wr_phase_timer.sv
module wr_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt  = cnt_q;
   assign zero = (cnt_q == '0);

endmodule

// File: rtl/wr_seq_fsm.sv
module wr_seq_fsm
   import sram_wr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int AS_CYC = 2,
   parameter int PW_CYC = 3,
   parameter int WR_CYC = 2,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              req_ready,
   input  logic              tmr_zero,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output wr_phase_e         phase,
   output logic [ADDR_W-1:0] addr_hold,
   output logic [DATA_W-1:0] data_hold
);

   localparam logic [CNT_W-1:0] AS_LOAD = CNT_W'(AS_CYC - 1);
   localparam logic [CNT_W-1:0] PW_LOAD = CNT_W'(PW_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

   wr_phase_e         phase_q, phase_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;

   assign req_ready = (phase_q == PH_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               phase_d  = PH_SETUP;
               tmr_load = 1'b1;
               tmr_val  = AS_LOAD;
            end
         end
         PH_SETUP: begin
            if (tmr_zero) begin
               phase_d  = PH_PULSE;
               tmr_load = 1'b1;
               tmr_val  = PW_LOAD;
            end
         end
         PH_PULSE: begin
            if (tmr_zero) begin
               phase_d  = PH_RECOV;
               tmr_load = 1'b1;
               tmr_val  = WR_LOAD;
            end
         end
         PH_RECOV: begin
            if (tmr_zero) begin
               phase_d = PH_DONE;
            end
         end
         PH_DONE: phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         phase_q <= phase_d;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
         end
      end
   end

   assign phase     = phase_q;
   assign addr_hold = addr_q;
   assign data_hold = data_q;

endmodule

// File: rtl/wr_pin_driver.sv
module wr_pin_driver
   import sram_wr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int PW_CYC    = 3,
   parameter int DW_CYC    = 2,
   parameter int DH_CYC    = 1,
   parameter int WR_CYC    = 2,
   parameter int CNT_W     = 2,
   parameter bit END_BY_CE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_phase_e         phase,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic              wr_done
);

   localparam int HOLD_FLOOR = WR_CYC - DH_CYC;

   logic     in_cycle;
   logic     in_pulse;
   logic     chip_act;
   logic     strobe_act;
   logic     drive_setup;
   logic     drive_hold;
   pin_set_t pins_d, pins_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign in_pulse = (phase == PH_PULSE);
   assign in_cycle = (phase == PH_SETUP) || in_pulse || (phase == PH_RECOV);

   generate
      if (END_BY_CE) begin : g_ce_ends
         assign chip_act   = in_pulse;
         assign strobe_act = in_cycle;
      end else begin : g_we_ends
         assign chip_act   = in_cycle;
         assign strobe_act = in_pulse;
      end
   endgenerate

   assign drive_setup = in_pulse && (int'(cnt) < DW_CYC);
   assign drive_hold  = (phase == PH_RECOV) && (int'(cnt) >= HOLD_FLOOR);

   always_comb begin
      pins_d       = PINS_IDLE;
      pins_d.ce1_n = ~chip_act;
      pins_d.ce2   = chip_act;
      pins_d.we_n  = ~strobe_act;
      pins_d.drive = drive_setup || drive_hold;
      pins_d.done  = (phase == PH_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_q <= PINS_IDLE;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         pins_q <= pins_d;
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = data_q;
   assign mem_dq_oe  = pins_q.drive;
   assign mem_ce1_n  = pins_q.ce1_n;
   assign mem_ce2    = pins_q.ce2;
   assign mem_we_n   = pins_q.we_n;
   assign mem_oe_n   = pins_q.oe_n;
   assign wr_done    = pins_q.done;

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
   import sram_wr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int AS_CYC    = 2,
   parameter int PW_CYC    = 3,
   parameter int DW_CYC    = 2,
   parameter int DH_CYC    = 1,
   parameter int WR_CYC    = 2,
   parameter bit END_BY_CE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              wr_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_we_n,
   output logic              mem_oe_n
);

   localparam int MAX_CYC = max3(AS_CYC, PW_CYC, WR_CYC);
   localparam int CNT_W   = cnt_width(MAX_CYC);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_wr_ctrl: bus widths must be positive");
      end
      if (AS_CYC < 1 || PW_CYC < 1 || DW_CYC < 1 || DH_CYC < 1 || WR_CYC < 1) begin : g_bad_count
         $error("sram_wr_ctrl: every phase count must be at least one");
      end
      if (DW_CYC > PW_CYC) begin : g_bad_setup
         $error("sram_wr_ctrl: data setup longer than write window");
      end
      if (DH_CYC > WR_CYC) begin : g_bad_hold
         $error("sram_wr_ctrl: data hold longer than recovery");
      end
   endgenerate

   wr_phase_e         phase;
   logic              tmr_load;
   logic              tmr_zero;
   logic [CNT_W-1:0]  tmr_val;
   logic [CNT_W-1:0]  tmr_cnt;
   logic [ADDR_W-1:0] addr_hold;
   logic [DATA_W-1:0] data_hold;

   wr_seq_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .AS_CYC (AS_CYC),
      .PW_CYC (PW_CYC),
      .WR_CYC (WR_CYC),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .req_ready (req_ready),
      .tmr_zero  (tmr_zero),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .phase     (phase),
      .addr_hold (addr_hold),
      .data_hold (data_hold)
   );

   wr_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt      (tmr_cnt),
      .zero     (tmr_zero)
   );

   wr_pin_driver #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PW_CYC    (PW_CYC),
      .DW_CYC    (DW_CYC),
      .DH_CYC    (DH_CYC),
      .WR_CYC    (WR_CYC),
      .CNT_W     (CNT_W),
      .END_BY_CE (END_BY_CE)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .cnt        (tmr_cnt),
      .addr_in    (addr_hold),
      .data_in    (data_hold),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .mem_ce1_n  (mem_ce1_n),
      .mem_ce2    (mem_ce2),
      .mem_we_n   (mem_we_n),
      .mem_oe_n   (mem_oe_n),
      .wr_done    (wr_done)
   );

endmodule

// File: rtl/sram_wr_ctrl_chk.sv
module sram_wr_ctrl_chk #(
   parameter int ADDR_W    = 16,
   parameter int PW_CYC    = 3,
   parameter bit END_BY_CE = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              wr_done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_dq_oe,
   input logic              mem_ce1_n,
   input logic              mem_ce2,
   input logic              mem_we_n,
   input logic              mem_oe_n
);

   logic        win;
   logic        busy_pins;
   logic [15:0] win_len;

   assign win       = !mem_ce1_n && mem_ce2 && !mem_we_n;
   assign busy_pins = !mem_ce1_n || !mem_we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_len <= '0;
      end else if (win) begin
         win_len <= win_len + 16'd1;
      end else begin
         win_len <= '0;
      end
   end

   AST_OE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_oe_n); // R2

   AST_WIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(win) |-> (win_len == 16'(PW_CYC))); // R3

   generate
      if (END_BY_CE) begin : g_ce_mode
         AST_CE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mem_ce1_n) |-> !mem_we_n); // R5
      end else begin : g_we_mode
         AST_WE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2)); // R4
      end
   endgenerate

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_pins && $past(busy_pins)) |-> $stable(mem_addr)); // R6

   AST_BUS_NEAR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n || (!mem_ce1_n && mem_ce2))); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done); // R8

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (mem_ce1_n && !mem_ce2 && mem_we_n && !mem_dq_oe)); // R8

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && !mem_dq_oe)); // R9

endmodule

bind sram_wr_ctrl sram_wr_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .PW_CYC    (PW_CYC),
   .END_BY_CE (END_BY_CE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .wr_done   (wr_done),
   .mem_addr  (mem_addr),
   .mem_dq_oe (mem_dq_oe),
   .mem_ce1_n (mem_ce1_n),
   .mem_ce2   (mem_ce2),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n)
);

// File: tb/sram_wr_ctrl_tb.sv
module sram_wr_ctrl_tb;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int AS = 2;
   localparam int PW = 3;
   localparam int DS = 2;
   localparam int DH = 1;
   localparam int WR = 2;
   localparam int T  = AS + PW + WR;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_w = 1'b0;
   logic req_c = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic mode = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic w_rdy, w_done, w_oe, w_ce1_n, w_ce2, w_we_n, w_oen;
   logic c_rdy, c_done, c_oe, c_ce1_n, c_ce2, c_we_n, c_oen;
   logic [AW-1:0] w_addr, c_addr;
   logic [DW-1:0] w_dq, c_dq;

   always #10 clk = ~clk;

   sram_wr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .AS_CYC(AS), .PW_CYC(PW), .DW_CYC(DS),
                  .DH_CYC(DH), .WR_CYC(WR), .END_BY_CE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_w), .req_ready(w_rdy),
      .req_addr(addr), .req_data(data), .wr_done(w_done), .mem_addr(w_addr),
      .mem_dq_out(w_dq), .mem_dq_oe(w_oe), .mem_ce1_n(w_ce1_n), .mem_ce2(w_ce2),
      .mem_we_n(w_we_n), .mem_oe_n(w_oen));

   sram_wr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .AS_CYC(AS), .PW_CYC(PW), .DW_CYC(DS),
                  .DH_CYC(DH), .WR_CYC(WR), .END_BY_CE(1'b1)) u_dut_ce (
      .clk(clk), .rst_n(rst_n), .req_valid(req_c), .req_ready(c_rdy),
      .req_addr(addr), .req_data(data), .wr_done(c_done), .mem_addr(c_addr),
      .mem_dq_out(c_dq), .mem_dq_oe(c_oe), .mem_ce1_n(c_ce1_n), .mem_ce2(c_ce2),
      .mem_we_n(c_we_n), .mem_oe_n(c_oen));

   wire s_rdy   = mode ? c_rdy   : w_rdy;
   wire s_done  = mode ? c_done  : w_done;
   wire s_oe    = mode ? c_oe    : w_oe;
   wire s_ce1_n = mode ? c_ce1_n : w_ce1_n;
   wire s_ce2   = mode ? c_ce2   : w_ce2;
   wire s_we_n  = mode ? c_we_n  : w_we_n;
   wire s_oen   = mode ? c_oen   : w_oen;
   wire [AW-1:0] s_addr = mode ? c_addr : w_addr;
   wire [DW-1:0] s_dq   = mode ? c_dq   : w_dq;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic bit exp_pulse(input int i);
      return (i >= AS) && (i < AS + PW);
   endfunction

   function automatic bit exp_drive(input int i);
      return (exp_pulse(i) && (i >= AS + PW - DS)) ||
             ((i >= AS + PW) && (i < AS + PW + DH));
   endfunction

   task automatic set_req(input bit v);
      if (mode) req_c = v; else req_w = v;
   endtask

   // caller is at a falling edge; returns at the falling edge before acceptance
   task automatic launch(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a;
      data = d;
      set_req(1'b1);
      while (!s_rdy) @(negedge clk);
   endtask

   task automatic observe(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit chain, input logic [AW-1:0] a2,
                          input logic [DW-1:0] d2);
      string tce;
      tce = mode ? "R5" : "R4";
      @(negedge clk);
      chk(s_done == 1'b0, "R8 done after prior", 32'(s_done), 0);
      if (chain) begin
         addr = a2;
         data = d2;
      end else begin
         set_req(1'b0);
      end
      for (int i = 0; i <= T; i++) begin
         @(negedge clk);
         chk(s_oen == 1'b1, "R2 oe_n", 32'(s_oen), 1);
         if (i < T) begin
            chk(s_ce1_n == !s_ce2, {tce, " enable pair"}, 32'({s_ce1_n, s_ce2}), 32'({!s_ce2, s_ce2}));
            chk(s_ce2 == (mode ? exp_pulse(i) : 1'b1), {tce, " enable"}, 32'(s_ce2),
                32'(mode ? exp_pulse(i) : 1'b1));
            chk(!s_we_n == (mode ? 1'b1 : exp_pulse(i)), {tce, " strobe"}, 32'(!s_we_n),
                32'(mode ? 1'b1 : exp_pulse(i)));
            chk((s_ce2 && !s_ce1_n && !s_we_n) == exp_pulse(i), "R3 window",
                32'(s_ce2 && !s_we_n), 32'(exp_pulse(i)));
            chk(s_addr == a, "R6 address", 32'(s_addr), 32'(a));
            chk(s_oe == exp_drive(i), "R7 drive", 32'(s_oe), 32'(exp_drive(i)));
            if (exp_drive(i)) chk(s_dq == d, "R7 data", 32'(s_dq), 32'(d));
            chk(s_done == 1'b0, "R8 done early", 32'(s_done), 0);
            chk(s_rdy == 1'b0, "R9 ready busy", 32'(s_rdy), 0);
         end else begin
            chk(s_done == 1'b1, "R8 done pulse", 32'(s_done), 1);
            chk(s_ce1_n && !s_ce2 && s_we_n && !s_oe, "R8 idle pins",
                32'({s_ce1_n, s_ce2, s_we_n, s_oe}), 32'(4'b1010));
            chk(s_rdy == 1'b1, "R9 ready again", 32'(s_rdy), 1);
         end
      end
   endtask

   task automatic one_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      launch(a, d);
      observe(a, d, 1'b0, '0, '0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      // R1 reset values on both variants
      for (int m = 0; m < 2; m++) begin
         mode = m[0];
         #1;
         chk(s_ce1_n && !s_ce2 && s_we_n && s_oen && !s_oe && !s_done && s_rdy,
             "R1 reset pins", 32'({s_ce1_n, s_ce2, s_we_n, s_oen, s_oe, s_done, s_rdy}),
             32'(7'b1011001));
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         mode = m[0];
         chk(s_ce1_n && !s_ce2 && s_we_n && !s_oe && s_rdy, "R1 idle after reset",
             32'({s_ce1_n, s_ce2, s_we_n, s_oe, s_rdy}), 32'(5'b10101));
         // directed corner values
         one_write('1, '0);
         one_write('0, '1);
         // R9 request held through a busy cycle: second write waits then runs
         launch(16'h1234, 8'hA5);
         observe(16'h1234, 8'hA5, 1'b1, 16'hBEEF, 8'h5A);
         launch(16'hBEEF, 8'h5A);
         observe(16'hBEEF, 8'h5A, 1'b0, '0, '0);
         // random traffic with idle gaps
         for (int n = 0; n < 30; n++) begin
            int gap;
            gap = int'($urandom_range(0, 4));
            repeat (gap) begin
               @(negedge clk);
               chk(s_rdy && s_ce1_n && s_we_n && !s_oe, "R9 idle between",
                   32'({s_rdy, s_ce1_n, s_we_n, s_oe}), 32'(4'b1110));
            end
            one_write(AW'($urandom), DW'($urandom));
         end
         repeat (3) @(negedge clk);
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule